// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects 64 interrupt lines and presents the CPU with one request line and a status word that names the single source to serve next. Every line has a 2-bit trigger code and a priority level. The trigger code selects one of four senses: low level, high level, falling edge or rising edge. Edge events are held in a sticky latch until software clears them. A level of zero keeps a source out of arbitration. Among the remaining pending sources, the highest level wins. A tie goes to the lowest source number.

Software reaches the block through a single-cycle register port that is addressed by 32-bit word index. A write takes effect at the clock edge where the write strobe is high. A read returns, in the same cycle, the word at the presented index. The sources arrive asynchronously, and each one passes through a two-flop synchronizer before any decision is made on it. Source number 0 is reserved and never wins.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the control word reads 0, every trigger-code word and every level word reads 0, the status word reads 0x0001_0000 and `irq_o` is low.
- R2: Trigger codes sit at word 16 + 2·bank + idx[3], where bank = source/32 and idx = source mod 32. Each code occupies bits [2f+1:2f], with f = {idx[4], idx[2:0]}. All 32 bits read back as written.
- R3: Levels sit at word 32 + 8·bank + (idx mod 16)/2, in the byte at bit 16·idx[4] + 8·idx[0]. Only the low 3 bits of each byte are stored. The upper 5 bits of each byte read as 0.
- R4: Word 0 bit 0 is the global enable, and its other bits read as 0. Word 1 is the read-only status word, and writes to it have no effect.
- R5: Code 0 makes a source pending while its input is low. Code 1 makes it pending while its input is high. The pending state follows the input within 2 clock cycles.
- R6: Code 2 latches a falling edge and code 3 latches a rising edge. The latch keeps the source pending after the input returns. An edge of the opposite direction does not set it.
- R7: Writing word 8 + bank clears edge latches. In the lower half, bit 8 is the enable and bits 3:0 give idx for idx 0–15. In the upper half, bit 24 is the enable and bits 19:16 give idx − 16 for idx 16–31. The command clears only the named source, and it does nothing when its enable bit is 0.
- R8: A source with level 0 never wins. Its edge latch is still captured, so raising the level later makes it pending.
- R9: The winner has the highest level among pending sources. On a tie, the lowest source number wins.
- R10: Source 0 never wins, whatever its code, level or input.
- R11: `irq_o` is high exactly when the global enable is set and some source is pending. The status word does not depend on the global enable.
- R12: Status bits 5:0 hold the winning source number, bit 16 is set when nothing is pending, and all other bits are 0. The number reads 0 when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src_i | input | 64 | Raw interrupt lines, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume the source lines are already synchronous enough that a two-flop stage removes metastability. They also assume a clear command and a new edge on the same source do not land in the same cycle. In that case the new edge would win and the clear property would not apply. The stimulus changes source lines only on the falling clock edge, and it holds each line for several cycles before reading status. It issues clear commands only while the addressed line is quiet. The stimulus writes only mapped word indexes and keeps the register port idle between accesses.

// File: rtl/prio_irq_pkg.sv
// Package: shared constants and types for the prioritized interrupt controller.
// Assumes 32-bit register words addressed by a 6-bit word index.
package prio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_mode_e;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 6;
    localparam int LVL_W      = 3;
    localparam int BANK_SRC   = 32;
    localparam int NOPEND_BIT = 16;
    localparam int CLR_EN_BIT = 8;

    localparam logic [ADDR_W-1:0] A_CTRL      = 6'd0;
    localparam logic [ADDR_W-1:0] A_STATUS    = 6'd1;
    localparam int                A_CLR_BASE  = 8;
    localparam int                A_MODE_BASE = 16;
    localparam int                A_LVL_BASE  = 32;

endpackage

// File: rtl/irq_front.sv
// Module: irq_front
// Synchronizes every source line, detects edges and keeps sticky edge
// latches, then forms the per-source pending flag from the trigger code.
// Assumes: source lines are asynchronous; clear strobes are single-cycle.
// When a new edge and a clear strike the same cycle, the edge wins.
module irq_front #(
    parameter int NUM_SRC = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_i,
    input  logic [NUM_SRC-1:0][1:0] mode_i,
    input  logic [NUM_SRC-1:0]      clr_i,
    output logic [NUM_SRC-1:0]      pend_o
);
    // Source 0 is reserved and is masked out here.
    localparam logic [NUM_SRC-1:0] USABLE = ~NUM_SRC'(1);

    logic [NUM_SRC-1:0] s1_q, s2_q, prev_q;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= src_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        logic is_edge, rise, fall, hit, lat_q, raw;

        assign is_edge = mode_i[k][1];
        assign rise    = s2_q[k] & ~prev_q[k];
        assign fall    = ~s2_q[k] & prev_q[k];
        assign hit     = is_edge & (mode_i[k][0] ? rise : fall);

        // Sticky edge latch: set by an edge, dropped by clear or level mode.
        always_ff @(posedge clk) begin
            if (!rst_n)            lat_q <= 1'b0;
            else if (hit)          lat_q <= 1'b1;
            else if (clr_i[k])     lat_q <= 1'b0;
            else if (!is_edge)     lat_q <= 1'b0;
        end

        assign raw       = is_edge ? lat_q : (s2_q[k] == mode_i[k][0]);
        assign pend_o[k] = raw & USABLE[k];

        // R6: a held edge stays latched until cleared or mode changes.
        assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q && is_edge && !clr_i[k]) |=> lat_q)
            else $error("edge latch dropped without clear on source %0d", k);

        // R7: a clear without a concurrent edge empties the latch.
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !hit) |=> !lat_q)
            else $error("clear command ignored on source %0d", k);
    end

endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs
// Register file: global enable, packed trigger-code words, packed level
// words and the indexed edge-clear command. Address decode is generated
// per source from its bank and in-bank index.
// Assumes: NUM_BANKS <= 4 so the map fits a 6-bit word index.
module irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int NUM_SRC   = NUM_BANKS * BANK_SRC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [DATA_W-1:0]           status_i,
    output logic [DATA_W-1:0]           rdata_o,
    output logic                        en_o,
    output logic [NUM_SRC-1:0][1:0]     mode_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o,
    output logic [NUM_SRC-1:0]          clr_o
);
    logic                             en_q;
    logic [NUM_SRC-1:0][DATA_W-1:0]   mode_rd;
    logic [NUM_SRC-1:0][DATA_W-1:0]   lvl_rd;

    // Global enable flop: only bit 0 of the control word is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                         en_q <= 1'b0;
        else if (we_i && addr_i == A_CTRL)  en_q <= wdata_i[0];
    end
    assign en_o = en_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int BK    = s / BANK_SRC;
        localparam int IX    = s % BANK_SRC;
        localparam int HI    = (IX >> 4) & 1;
        localparam logic [ADDR_W-1:0] MADDR =
            ADDR_W'(A_MODE_BASE + 2 * BK + ((IX >> 3) & 1));
        localparam int MOFS  = 2 * (HI * 8 + (IX & 7));
        localparam logic [ADDR_W-1:0] LADDR =
            ADDR_W'(A_LVL_BASE + 8 * BK + (IX % 16) / 2);
        localparam int LOFS  = HI * 16 + (IX & 1) * 8;
        localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(A_CLR_BASE + BK);
        localparam int CHALF = HI * 16;

        logic [1:0]       m_q;
        logic [LVL_W-1:0] l_q;

        // Trigger-code field of this source.
        always_ff @(posedge clk) begin
            if (!rst_n)                        m_q <= TRIG_LOW;
            else if (we_i && addr_i == MADDR)  m_q <= wdata_i[MOFS +: 2];
        end

        // Priority level field of this source (low 3 bits of its byte).
        always_ff @(posedge clk) begin
            if (!rst_n)                        l_q <= '0;
            else if (we_i && addr_i == LADDR)  l_q <= wdata_i[LOFS +: LVL_W];
        end

        assign mode_o[s] = m_q;
        assign lvl_o[s]  = l_q;
        assign clr_o[s]  = we_i && (addr_i == CADDR)
                        && wdata_i[CHALF + CLR_EN_BIT]
                        && (wdata_i[CHALF +: 4] == 4'(IX % 16));
        assign mode_rd[s] = (addr_i == MADDR) ? (DATA_W'(m_q) << MOFS) : '0;
        assign lvl_rd[s]  = (addr_i == LADDR) ? (DATA_W'(l_q) << LOFS) : '0;
    end

    // Read mux: fixed words plus the OR of every field that maps here.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:   rdata_o = DATA_W'(en_q);
            A_STATUS: rdata_o = status_i;
            default:  rdata_o = '0;
        endcase
        for (int s = 0; s < NUM_SRC; s++) begin
            rdata_o = rdata_o | mode_rd[s] | lvl_rd[s];
        end
    end

endmodule

// File: rtl/irq_arb.sv
// Module: irq_arb
// Combinational binary comparison tree. Each node keeps the higher level;
// on equal levels the left child (lower source number) is kept.
// Assumes: N is a power of two; a level of 0 means "not competing".
module irq_arb #(
    parameter int N  = 64,
    parameter int LW = 3,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0][LW-1:0] lvl_i,
    output logic [IW-1:0]        idx_o,
    output logic [LW-1:0]        lvl_o
);
    for (genvar st = 0; st <= IW; st++) begin : g_st
        localparam int W = N >> st;
        logic [W-1:0][LW-1:0] nl;
        logic [W-1:0][IW-1:0] ni;

        if (st == 0) begin : g_leaf
            for (genvar k = 0; k < W; k++) begin : g_k
                assign nl[k] = lvl_i[k];
                assign ni[k] = IW'(k);
            end
        end else begin : g_node
            for (genvar k = 0; k < W; k++) begin : g_k
                logic pick_r;
                // Right child wins only on a strictly higher level.
                assign pick_r = g_st[st-1].nl[2*k+1] > g_st[st-1].nl[2*k];
                assign nl[k]  = pick_r ? g_st[st-1].nl[2*k+1] : g_st[st-1].nl[2*k];
                assign ni[k]  = pick_r ? g_st[st-1].ni[2*k+1] : g_st[st-1].ni[2*k];
            end
        end
    end

    assign idx_o = g_st[IW].ni[0];
    assign lvl_o = g_st[IW].nl[0];

endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Prioritized vectored interrupt controller: source front end, register
// file and arbitration tree; forms the status word and the CPU request.
// Assumes: NUM_BANKS is 1, 2 or 4 (power-of-two source count).
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*BANK_SRC-1:0] irq_src_i,
    input  logic                          reg_we_i,
    input  logic [ADDR_W-1:0]             reg_addr_i,
    input  logic [DATA_W-1:0]             reg_wdata_i,
    output logic [DATA_W-1:0]             reg_rdata_o,
    output logic                          irq_o
);
    localparam int NUM_SRC = NUM_BANKS * BANK_SRC;
    localparam int VEC_W   = $clog2(NUM_SRC);

    logic                          glb_en;
    logic [NUM_SRC-1:0][1:0]       mode;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [NUM_SRC-1:0][LVL_W-1:0] eff_lvl;
    logic [NUM_SRC-1:0]            clr;
    logic [NUM_SRC-1:0]            pend;
    logic [VEC_W-1:0]              win_idx;
    logic [LVL_W-1:0]              win_lvl;
    logic                          nopend;
    logic [DATA_W-1:0]             status;

    irq_regs #(.NUM_BANKS(NUM_BANKS), .NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status),
        .rdata_o  (reg_rdata_o),
        .en_o     (glb_en),
        .mode_o   (mode),
        .lvl_o    (lvl),
        .clr_o    (clr)
    );

    irq_front #(.NUM_SRC(NUM_SRC)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (irq_src_i),
        .mode_i (mode),
        .clr_i  (clr),
        .pend_o (pend)
    );

    // Only pending sources compete, with their programmed level.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_eff
        assign eff_lvl[k] = pend[k] ? lvl[k] : '0;
    end

    irq_arb #(.N(NUM_SRC), .LW(LVL_W), .IW(VEC_W)) u_arb (
        .lvl_i (eff_lvl),
        .idx_o (win_idx),
        .lvl_o (win_lvl)
    );

    // Status word and request: vector forced to 0 when nothing competes.
    assign nopend = (win_lvl == '0);
    assign status = (DATA_W'(nopend) << NOPEND_BIT)
                  | (nopend ? '0 : DATA_W'(win_idx));
    assign irq_o  = glb_en & ~nopend;

    // R10: a reported winner is never the reserved source.
    assert_vec_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !nopend |-> (win_idx != '0))
        else $error("reserved source reported as winner");

    // R8: a reported winner is pending and has a nonzero level.
    assert_win_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nopend |-> (lvl[win_idx] != '0 && pend[win_idx]))
        else $error("winner %0d not enabled or not pending", win_idx);

    // R9: no competitor beats the winner, and ties favour the lower number.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                assert_max_R9: assert (eff_lvl[k] <= win_lvl)
                    else $error("source %0d outranks winner", k);
                if (eff_lvl[k] == win_lvl && win_lvl != '0) begin
                    assert_tie_R9: assert (VEC_W'(k) >= win_idx)
                        else $error("tie lost by lower source %0d", k);
                end
            end
        end
    end

endmodule

// File: tb/test_prio_irq_ctrl.sv
// Scoreboard bench: driver tasks push expected results into a queue; a
// monitor pops each item one step after the falling edge and compares.
module test_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic        we;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    always #5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       q[$];
    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;
    logic [31:0] sh[64];

    localparam logic [31:0] NONE = 32'h0001_0000;

    // Monitor: compare every queued expectation against the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = it.is_irq ? 32'(irq) : rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %h exp %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; sh[a] = d;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        we = 1'b0; addr = a;
        q.push_back('{1'b0, e, t});
    endtask

    task automatic st_chk(input logic [31:0] e, input string t);
        rd_chk(6'd1, e, t);
    endtask

    task automatic irq_chk(input logic e, input string t);
        @(negedge clk);
        q.push_back('{1'b1, 32'(e), t});
    endtask

    task automatic set_mode(input int s, input logic [1:0] m);
        int a, f; logic [31:0] d;
        a = 16 + 2 * (s / 32) + (((s % 32) >> 3) & 1);
        f = (((s % 32) >> 4) & 1) * 8 + (s % 8);
        d = sh[a]; d[2*f +: 2] = m;
        wr(6'(a), d);
    endtask

    task automatic set_lvl(input int s, input logic [7:0] l);
        int a, o; logic [31:0] d;
        a = 32 + 8 * (s / 32) + ((s % 32) % 16) / 2;
        o = (((s % 32) >> 4) & 1) * 16 + (s % 2) * 8;
        d = sh[a]; d[o +: 8] = l;
        wr(6'(a), d);
    endtask

    task automatic clr_cmd(input int bank, input int half, input bit en, input int ix);
        logic [31:0] d;
        d = ((32'(en) << 8) | 32'(ix)) << (half * 16);
        wr(6'(8 + bank), d);
    endtask

    task automatic clear_src(input int s);
        clr_cmd(s / 32, (s % 32) / 16, 1'b1, s % 16);
    endtask

    task automatic drive(input int k, input logic v);
        @(negedge clk);
        src[k] = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all R): got timeout exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) sh[i] = '0;
        rst_n = 1'b0; src = '0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd_chk(6'd0, 32'h0, "R1 ctrl after reset");
        st_chk(NONE, "R1 status after reset");
        irq_chk(1'b0, "R1 irq after reset");
        rd_chk(6'd17, 32'h0, "R1 mode word after reset");
        rd_chk(6'd45, 32'h0, "R1 level word after reset");

        // R2 / R3 / R4: register read-back
        wr(6'd17, 32'hA5A5_5A5A);
        rd_chk(6'd17, 32'hA5A5_5A5A, "R2 mode word readback");
        wr(6'd17, 32'h0);
        wr(6'd33, 32'hFFFF_FFFF);
        rd_chk(6'd33, 32'h0707_0707, "R3 level reserved bits");
        wr(6'd33, 32'h0);
        wr(6'd0, 32'hFFFF_FFFF);
        rd_chk(6'd0, 32'h1, "R4 ctrl reserved bits");
        wr(6'd0, 32'h0);
        wr(6'd1, 32'h0000_0025);
        st_chk(NONE, "R4 status write ignored");

        // R5 / R11: level modes and global enable
        set_mode(5, 2'd1); set_lvl(5, 8'd3);
        st_chk(NONE, "R5 high-level idle");
        wr(6'd0, 32'h1);
        drive(5, 1'b1);
        st_chk(32'd5, "R5 high-level active");
        irq_chk(1'b1, "R11 irq enabled");
        wr(6'd0, 32'h0);
        irq_chk(1'b0, "R11 irq disabled");
        st_chk(32'd5, "R11 status ignores enable");
        wr(6'd0, 32'h1);
        drive(5, 1'b0);
        st_chk(NONE, "R5 high-level released");
        irq_chk(1'b0, "R11 irq nothing pending");
        set_mode(5, 2'd0);
        st_chk(32'd5, "R5 low-level active");
        set_lvl(5, 8'd0);
        st_chk(NONE, "R8 level zero masks");

        // R6 / R7: rising edge, clear in upper half of bank 0
        set_mode(20, 2'd3); set_lvl(20, 8'd2);
        st_chk(NONE, "R6 rising idle");
        drive(20, 1'b1);
        st_chk(32'd20, "R6 rising captured");
        drive(20, 1'b0);
        st_chk(32'd20, "R6 rising sticky");
        clr_cmd(0, 1, 1'b0, 4);
        st_chk(32'd20, "R7 clear without enable");
        clr_cmd(0, 1, 1'b1, 5);
        st_chk(32'd20, "R7 clear other index");
        clr_cmd(0, 0, 1'b1, 4);
        st_chk(32'd20, "R7 clear wrong half");
        clear_src(20);
        st_chk(NONE, "R7 clear upper half bank0");
        set_lvl(20, 8'd0);

        // R6 / R7: falling edge, clear in lower half of bank 1
        drive(40, 1'b1);
        set_mode(40, 2'd2); set_lvl(40, 8'd4);
        st_chk(NONE, "R6 falling idle");
        drive(40, 1'b0);
        st_chk(32'd40, "R6 falling captured");
        clear_src(40);
        st_chk(NONE, "R7 clear lower half bank1");
        drive(40, 1'b1);
        st_chk(NONE, "R6 falling ignores rise");
        set_lvl(40, 8'd0);

        // R9: priority and ties
        set_mode(10, 2'd1); set_mode(50, 2'd1); set_mode(60, 2'd1);
        set_lvl(10, 8'd6); set_lvl(50, 8'd6); set_lvl(60, 8'd2);
        drive(60, 1'b1);
        st_chk(32'd60, "R9 single source");
        drive(50, 1'b1);
        st_chk(32'd50, "R9 higher level wins");
        drive(10, 1'b1);
        st_chk(32'd10, "R9 tie lowest number");
        set_lvl(50, 8'd7);
        st_chk(32'd50, "R9 raised level wins");
        drive(50, 1'b0);
        st_chk(32'd10, "R9 fallback");
        drive(10, 1'b0);
        st_chk(32'd60, "R9 low level last");
        drive(60, 1'b0);
        st_chk(NONE, "R12 none after drain");

        // R8: latch captured while level is zero
        set_mode(33, 2'd3);
        drive(33, 1'b1);
        drive(33, 1'b0);
        st_chk(NONE, "R8 level zero hides latch");
        set_lvl(33, 8'd1);
        st_chk(32'd33, "R8 latch revealed");
        clear_src(33);
        st_chk(NONE, "R7 clear bank1 idx1");

        // R10: reserved source
        set_mode(0, 2'd1); set_lvl(0, 8'd7);
        drive(0, 1'b1);
        st_chk(NONE, "R10 source 0 never wins");
        irq_chk(1'b0, "R10 no irq from source 0");

        // R7 / R12: top source, upper half of bank 1
        set_mode(63, 2'd3); set_lvl(63, 8'd1);
        drive(63, 1'b1);
        st_chk(32'd63, "R12 vector 63");
        irq_chk(1'b1, "R11 irq source 63");
        clear_src(63);
        st_chk(NONE, "R7 clear upper half bank1");
        irq_chk(1'b0, "R11 irq after clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule